// File: doc/BRIEF.md
# Port-Controlled Line Sync and NMI Generator

This block sits beside the CPU of a small 8-bit computer whose picture is timed by software. A free-running line counter, clocked by the CPU clock, divides time into horizontal lines. It produces a horizontal sync pulse at a fixed position in each line. When software has switched it on, it also produces a short active-low NMI request at each line boundary. The NMI lets the margin-line code keep pace with the beam.

Software controls the block through plain I/O cycles. A write to one port turns the NMI source on and a write to another turns it off. Reading the keyboard port starts vertical sync, and any write to port $FF ends it. A 3-bit scanline counter steps once for every horizontal sync. The character generator uses this counter to pick the pixel row. Vertical sync holds the counter at zero. Horizontal syncs come only from the line counter, so I/O cycles and interrupt acknowledge cycles never add a sync or an extra count.

Top module: `sync_nmi_gen`

## Requirements
- R1: While reset is high, hsync is 0, nmi_n is 1, csync_n is 1 and scan_line is 0. Reset also clears the NMI enable and the vertical sync state, and puts the line position at 0.
- R2: The line position counts 0 to 206 and then returns to 0, so hsync rises once every 207 clock cycles.
- R3: hsync is 1 exactly while the line position is 16 through 30, which is 15 cycles. The line position is 0 in the first cycle after reset is released and advances by one each clock.
- R4: A write cycle to address $FE (iorq_n=0, wr_n=0, m1_n=1) turns the NMI source on. While it is on and vertical sync is inactive, nmi_n is 0 at line positions 0 to 3 and 1 at every other position.
- R5: A write cycle to address $FD turns the NMI source off. After that, nmi_n stays 1.
- R6: A read cycle to address $FE (iorq_n=0, rd_n=0, m1_n=1) starts vertical sync. While vertical sync is active, csync_n is 0 and nmi_n is 1. Outside vertical sync, csync_n is the inverse of hsync.
- R7: A write cycle to address $FF ends vertical sync.
- R8: Outside vertical sync, scan_line increases by 1 (modulo 8) one cycle after hsync rises. After 56 horizontal syncs counted from the end of vertical sync, it is back at 0.
- R9: scan_line reads 0 for as long as vertical sync is active. Ending vertical sync does not change scan_line.
- R10: No I/O cycle changes hsync or scan_line. This covers NMI on/off writes and interrupt acknowledge cycles (iorq_n=0 with m1_n=0). An interrupt acknowledge cycle changes no state. A bus cycle acts once, in its first clock, however long the strobes stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| iorq_n | input | 1 | I/O request strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| m1_n | input | 1 | Opcode fetch / acknowledge marker, active low |
| addr | input | 8 | Low byte of the address bus |
| hsync | output | 1 | Horizontal sync pulse, active high |
| nmi_n | output | 1 | Non-maskable interrupt request, active low |
| csync_n | output | 1 | Composite sync level, low during hsync or vertical sync |
| scan_line | output | 3 | Pixel row counter for the character generator |

## Verification
The bench goes after the edges of the control writes. It checks that an NMI on/off write placed mid-line adds no sync pulse and no count. A design that reproduced the old preset flip-flop would show an extra hsync and a stepped scan_line there. It checks that ending vertical sync leaves scan_line at 0 until the next regular sync. A design that counted that edge would start the picture one row off. It also runs 56 lines after vertical sync and checks that the counter lands on 0, which catches a wrong wrap or a skipped count. Finally, it checks that NMI stays quiet during vertical sync and after the disable write, so a missing gate would show up as a stray NMI request.

// File: rtl/sync_nmi_pkg.sv
package sync_nmi_pkg;

    // Decoded, single-cycle bus commands
    typedef struct packed {
        logic nmi_on;
        logic nmi_off;
        logic vs_start;
        logic vs_end;
    } io_cmd_t;

    localparam io_cmd_t IO_CMD_NONE = '{nmi_on: 1'b0, nmi_off: 1'b0, vs_start: 1'b0, vs_end: 1'b0};

    // Default port numbers
    localparam logic [7:0] DEF_PORT_NMI_ON  = 8'hFE;
    localparam logic [7:0] DEF_PORT_NMI_OFF = 8'hFD;
    localparam logic [7:0] DEF_PORT_KBD     = 8'hFE;
    localparam logic [7:0] DEF_PORT_VS_END  = 8'hFF;

    function automatic logic port_is(input logic [7:0] a, input logic [7:0] p);
        return a == p;
    endfunction

endpackage

// File: rtl/sync_nmi_line_timer.sv
module sync_nmi_line_timer #(
    parameter int LINE_CYCLES = 207,
    parameter int HS_START    = 16,
    parameter int HS_WIDTH    = 15,
    parameter int NMI_WIDTH   = 4
) (
    input  logic clk,
    input  logic rst,
    output logic hsync,
    output logic hs_start,
    output logic nmi_win
);
    localparam int CW = $clog2(LINE_CYCLES);
    typedef logic [CW-1:0] cnt_t;
    localparam cnt_t LAST     = cnt_t'(LINE_CYCLES - 1);
    localparam cnt_t HS_FIRST = cnt_t'(HS_START);
    localparam cnt_t HS_LAST  = cnt_t'(HS_START + HS_WIDTH - 1);
    localparam cnt_t NMI_LAST = cnt_t'(NMI_WIDTH - 1);

    cnt_t pos_q;

    always_ff @(posedge clk) begin
        if (rst)                pos_q <= '0;
        else if (pos_q == LAST) pos_q <= '0;
        else                    pos_q <= pos_q + 1'b1;
    end

    assign hsync    = (pos_q >= HS_FIRST) && (pos_q <= HS_LAST);
    assign hs_start = (pos_q == HS_FIRST);
    assign nmi_win  = (pos_q <= NMI_LAST);

    // Line period wraps at the configured length
    assert_line_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (pos_q == LAST) |=> (pos_q == '0));

    // Sync pulse ends right after its last position
    assert_hs_end_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(hsync) |-> ($past(pos_q) == HS_LAST));

endmodule

// File: rtl/sync_nmi_io_decode.sv
module sync_nmi_io_decode
    import sync_nmi_pkg::*;
#(
    parameter logic [7:0] PORT_NMI_ON  = DEF_PORT_NMI_ON,
    parameter logic [7:0] PORT_NMI_OFF = DEF_PORT_NMI_OFF,
    parameter logic [7:0] PORT_KBD     = DEF_PORT_KBD,
    parameter logic [7:0] PORT_VS_END  = DEF_PORT_VS_END
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       iorq_n,
    input  logic       wr_n,
    input  logic       rd_n,
    input  logic       m1_n,
    input  logic [7:0] addr,
    output io_cmd_t    cmd
);
    logic wr_stb, rd_stb, wr_q, rd_q, wr_go, rd_go;

    // Acknowledge cycles (m1_n low) are not I/O transfers
    assign wr_stb = !iorq_n && !wr_n && m1_n;
    assign rd_stb = !iorq_n && !rd_n && m1_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_stb;
            rd_q <= rd_stb;
        end
    end

    assign wr_go = wr_stb && !wr_q;
    assign rd_go = rd_stb && !rd_q;

    always_comb begin
        cmd          = IO_CMD_NONE;
        cmd.nmi_on   = wr_go && port_is(addr, PORT_NMI_ON);
        cmd.nmi_off  = wr_go && port_is(addr, PORT_NMI_OFF);
        cmd.vs_end   = wr_go && port_is(addr, PORT_VS_END);
        cmd.vs_start = rd_go && port_is(addr, PORT_KBD);
    end

    // A held strobe yields a single command
    assert_single_shot_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd.nmi_on || cmd.nmi_off || cmd.vs_end) |=> !(cmd.nmi_on || cmd.nmi_off || cmd.vs_end));

endmodule

// File: rtl/sync_nmi_ctrl.sv
module sync_nmi_ctrl
    import sync_nmi_pkg::*;
#(
    parameter int SCAN_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  io_cmd_t              cmd,
    input  logic                 hs_start,
    output logic                 nmi_en,
    output logic                 vsync,
    output logic [SCAN_BITS-1:0] scan
);
    logic vs_next;

    always_comb begin
        vs_next = vsync;
        if (cmd.vs_end)   vs_next = 1'b0;
        if (cmd.vs_start) vs_next = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_en <= 1'b0;
            vsync  <= 1'b0;
            scan   <= '0;
        end else begin
            if (cmd.nmi_on)       nmi_en <= 1'b1;
            else if (cmd.nmi_off) nmi_en <= 1'b0;
            vsync <= vs_next;
            if (vs_next)       scan <= '0;
            else if (hs_start) scan <= scan + 1'b1;
        end
    end

    // Counter only ever steps forward by one outside vertical sync
    assert_scan_step_R8: assert property (@(posedge clk) disable iff (rst)
        (!vsync && (scan != $past(scan))) |-> (scan == SCAN_BITS'($past(scan) + 1'b1)));

    // Counter held at zero during vertical sync
    assert_vs_clear_R9: assert property (@(posedge clk) disable iff (rst)
        vsync |-> (scan == '0));

    // Counter only moves on a sync start or a vertical sync change
    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(hs_start) && !$past(vs_next)) |-> $stable(scan));

endmodule

// File: rtl/sync_nmi_gen.sv
module sync_nmi_gen
    import sync_nmi_pkg::*;
#(
    parameter int         LINE_CYCLES  = 207,
    parameter int         HS_START     = 16,
    parameter int         HS_WIDTH     = 15,
    parameter int         NMI_WIDTH    = 4,
    parameter int         SCAN_BITS    = 3,
    parameter logic [7:0] PORT_NMI_ON  = DEF_PORT_NMI_ON,
    parameter logic [7:0] PORT_NMI_OFF = DEF_PORT_NMI_OFF,
    parameter logic [7:0] PORT_KBD     = DEF_PORT_KBD,
    parameter logic [7:0] PORT_VS_END  = DEF_PORT_VS_END
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 iorq_n,
    input  logic                 wr_n,
    input  logic                 rd_n,
    input  logic                 m1_n,
    input  logic [7:0]           addr,
    output logic                 hsync,
    output logic                 nmi_n,
    output logic                 csync_n,
    output logic [SCAN_BITS-1:0] scan_line
);
    io_cmd_t cmd;
    logic    hs_start, nmi_win, nmi_en, vsync;

    sync_nmi_line_timer #(
        .LINE_CYCLES(LINE_CYCLES), .HS_START(HS_START),
        .HS_WIDTH(HS_WIDTH), .NMI_WIDTH(NMI_WIDTH)
    ) u_timer (
        .clk(clk), .rst(rst), .hsync(hsync), .hs_start(hs_start), .nmi_win(nmi_win)
    );

    sync_nmi_io_decode #(
        .PORT_NMI_ON(PORT_NMI_ON), .PORT_NMI_OFF(PORT_NMI_OFF),
        .PORT_KBD(PORT_KBD), .PORT_VS_END(PORT_VS_END)
    ) u_dec (
        .clk(clk), .rst(rst), .iorq_n(iorq_n), .wr_n(wr_n), .rd_n(rd_n),
        .m1_n(m1_n), .addr(addr), .cmd(cmd)
    );

    sync_nmi_ctrl #(.SCAN_BITS(SCAN_BITS)) u_ctrl (
        .clk(clk), .rst(rst), .cmd(cmd), .hs_start(hs_start),
        .nmi_en(nmi_en), .vsync(vsync), .scan(scan_line)
    );

    assign nmi_n   = !(nmi_en && !vsync && nmi_win);
    assign csync_n = !(hsync || vsync);

    // NMI request quiet during vertical sync
    assert_nmi_vs_gate_R6: assert property (@(posedge clk) disable iff (rst)
        vsync |-> nmi_n);

    // NMI request quiet while the source is off
    assert_nmi_off_R5: assert property (@(posedge clk) disable iff (rst)
        !nmi_en |-> nmi_n);

    // Composite level low throughout vertical sync
    assert_csync_vs_R6: assert property (@(posedge clk) disable iff (rst)
        vsync |-> !csync_n);

endmodule

// File: tb/sync_nmi_gen_bench.sv
module sync_nmi_gen_bench;
    localparam int LINE = 207;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic iorq_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, m1_n = 1'b1;
    logic [7:0] addr = 8'h00;
    logic hsync, nmi_n, csync_n;
    logic [2:0] scan_line;

    int pass_cnt = 0;
    int fail_cnt = 0;

    always #4 clk = ~clk;

    sync_nmi_gen u_sync_nmi_gen (
        .clk(clk), .rst(rst), .iorq_n(iorq_n), .wr_n(wr_n), .rd_n(rd_n),
        .m1_n(m1_n), .addr(addr), .hsync(hsync), .nmi_n(nmi_n),
        .csync_n(csync_n), .scan_line(scan_line)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        if (ok) pass_cnt++;
        else begin
            fail_cnt++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: cycle count since reset and command flags
    int m_pos = 0, m_sc = 0;
    bit m_en = 0, m_vs = 0, m_pw = 0, m_pr = 0;

    always @(posedge clk) begin
        bit sw, sr;
        sw = !iorq_n && !wr_n && m1_n;
        sr = !iorq_n && !rd_n && m1_n;
        if (rst) begin
            m_pos = 0; m_sc = 0; m_en = 0; m_vs = 0; m_pw = 0; m_pr = 0;
        end else begin
            if (sw && !m_pw) begin
                if (addr == 8'hFE) m_en = 1;
                if (addr == 8'hFD) m_en = 0;
                if (addr == 8'hFF) m_vs = 0;
            end
            if (sr && !m_pr && addr == 8'hFE) m_vs = 1;
            if (m_vs) m_sc = 0;
            else if (m_pos == 16) m_sc = (m_sc + 1) % 8;
            m_pos = (m_pos + 1) % LINE;
            m_pw = sw;
            m_pr = sr;
        end
    end

    // Compare against the reference on every clock
    always @(negedge clk) begin
        if (!rst) begin
            bit e_hs;
            e_hs = (m_pos >= 16) && (m_pos < 31);
            chk(hsync == e_hs, "R3 hsync", int'(hsync), int'(e_hs));
            chk(nmi_n == !(m_en && !m_vs && m_pos < 4), "R4 nmi_n", int'(nmi_n),
                int'(!(m_en && !m_vs && m_pos < 4)));
            chk(csync_n == !(e_hs || m_vs), "R6 csync_n", int'(csync_n), int'(!(e_hs || m_vs)));
            chk(int'(scan_line) == m_sc, "R8 scan_line", int'(scan_line), m_sc);
        end
    end

    task automatic bus(input bit is_wr, input logic [7:0] a, input bit ack);
        @(negedge clk);
        addr = a;
        iorq_n = 1'b0;
        if (ack) m1_n = 1'b0;
        else if (is_wr) wr_n = 1'b0;
        else rd_n = 1'b0;
        repeat (3) @(negedge clk);
        iorq_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; m1_n = 1'b1;
    endtask

    task automatic wait_pos(input int p);
        @(negedge clk);
        while (m_pos != p) @(negedge clk);
    endtask

    task automatic wait_rise();
        @(negedge clk);
        while (hsync) @(negedge clk);
        while (!hsync) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fail_cnt++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        time t0, t1;
        int  sc0;
        bit  hs_seen;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(hsync == 1'b0, "R1 hsync", int'(hsync), 0);
        chk(nmi_n == 1'b1, "R1 nmi_n", int'(nmi_n), 1);
        chk(csync_n == 1'b1, "R1 csync_n", int'(csync_n), 1);
        chk(scan_line == 3'd0, "R1 scan_line", int'(scan_line), 0);
        rst = 1'b0;

        // R2: line period, R3: pulse width
        wait_rise(); t0 = $time;
        wait_rise(); t1 = $time;
        chk((t1 - t0) == LINE * 8, "R2 period", int'((t1 - t0) / 8), LINE);
        @(negedge clk);
        while (hsync) @(negedge clk);
        chk(($time - t1) == 15 * 8, "R3 width", int'(($time - t1) / 8), 15);

        // R6: keyboard read starts vertical sync
        wait_pos(100);
        bus(1'b0, 8'hFE, 1'b0);
        @(negedge clk);
        chk(csync_n == 1'b0, "R6 csync during vsync", int'(csync_n), 0);
        chk(scan_line == 3'd0, "R9 scan at vsync", int'(scan_line), 0);
        wait_rise(); @(negedge clk); @(negedge clk);
        chk(scan_line == 3'd0, "R9 scan held in vsync", int'(scan_line), 0);

        // R7: write $FF ends vertical sync, no count from that edge
        wait_pos(150);
        bus(1'b1, 8'hFF, 1'b0);
        wait_pos(170);
        chk(csync_n == 1'b1, "R7 vsync ended", int'(csync_n), 1);
        chk(scan_line == 3'd0, "R9 no count at vsync end", int'(scan_line), 0);
        wait_rise(); @(negedge clk);
        chk(scan_line == 3'd1, "R8 first count", int'(scan_line), 1);

        // R4: enable NMI
        wait_pos(60);
        bus(1'b1, 8'hFE, 1'b0);
        wait_pos(1);
        chk(nmi_n == 1'b0, "R4 nmi at line start", int'(nmi_n), 0);
        wait_pos(5);
        chk(nmi_n == 1'b1, "R4 nmi released", int'(nmi_n), 1);

        // R10: I/O cycles mid-line add no sync and no count
        wait_pos(60);
        sc0 = int'(scan_line);
        bus(1'b1, 8'hFD, 1'b0);
        bus(1'b1, 8'hFE, 1'b0);
        bus(1'b0, 8'h00, 1'b1);
        hs_seen = 0;
        while (m_pos != 200) begin
            @(negedge clk);
            if (hsync) hs_seen = 1;
        end
        chk(!hs_seen, "R10 no spurious hsync", int'(hs_seen), 0);
        chk(int'(scan_line) == sc0, "R10 scan unchanged", int'(scan_line), sc0);
        wait_pos(2);
        chk(nmi_n == 1'b0, "R10 ack left nmi enabled", int'(nmi_n), 0);

        // R8: 56 syncs since vertical sync end bring the counter to 0
        // (2 counted so far plus this line's)
        repeat (2) wait_rise();
        @(negedge clk);
        chk(scan_line == 3'd4, "R8 count 4", int'(scan_line), 4);
        repeat (52) wait_rise();
        @(negedge clk);
        chk(scan_line == 3'd0, "R8 wrap after 56", int'(scan_line), 0);

        // R6: NMI suppressed during vertical sync
        wait_pos(100);
        bus(1'b0, 8'hFE, 1'b0);
        wait_pos(2);
        chk(nmi_n == 1'b1, "R6 nmi gated by vsync", int'(nmi_n), 1);
        wait_pos(100);
        bus(1'b1, 8'hFF, 1'b0);
        wait_pos(2);
        chk(nmi_n == 1'b0, "R7 nmi back after vsync", int'(nmi_n), 0);

        // R5: disable NMI
        wait_pos(100);
        bus(1'b1, 8'hFD, 1'b0);
        wait_pos(2);
        chk(nmi_n == 1'b1, "R5 nmi off", int'(nmi_n), 1);
        wait_pos(2);
        chk(nmi_n == 1'b1, "R5 nmi stays off", int'(nmi_n), 1);

        summary();
        $finish;
    end
endmodule